// File: doc/BRIEF.md
# Fixed-Point Square Root by Reciprocal Newton Iteration

This unit computes the square root of an unsigned 32-bit fixed-point number. The value has two integer bits above thirty fractional bits. The unit does not extract the root one digit at a time. Instead it first refines an estimate of the reciprocal square root with Newton steps that use only multiplication: p' = p·(3 − x·p²)/2. It then multiplies the converged reciprocal by the radicand to form the root. The answer is approximate by design, and the number of Newton steps controls the error.

Before iterating, the radicand is shifted left by an even amount so that its leading one falls in the top two bits. This places the normalised value in [1, 4). A small table, indexed by the top bits of the normalised value, supplies the starting estimate. After the final multiply the root is shifted back by half the normalisation shift, and the reciprocal is scaled up by the same amount. One multiplier is shared by every step, so each result takes a fixed number of cycles. A start pulse launches a computation, and a one-cycle done pulse marks the new results.

Top module: `nr_sqrt`

## Requirements
- R1: While reset is held and after it is released, root and recip read 0 and done reads 0 until the first result.
- R2: For a start that is accepted at a clock edge, done is high for exactly one cycle after the edge 3·ITERS+1 cycles later. With the default ITERS of 3 this is 10 cycles.
- R3: For a nonzero radicand X, read as X/2^30, root is within 2 LSB of floor(sqrt(X·2^30)). root is read in the same Q2.30 format.
- R4: For a nonzero radicand X, recip is an unsigned Q16.16 value within 2 + 2^-24 of its expected value, in relative terms, of 2^31/sqrt(X).
- R5: A radicand of zero gives root = 0 and recip = 0xFFFFFFFF, with the same latency as any other input.
- R6: A start that arrives while a computation is in progress is ignored. This includes the edge at which that computation raises done. An ignored start causes no extra done pulse and does not change the result.
- R7: root and recip change only at the edge that raises done. They hold their values in every other cycle.
- R8: The radicand is sampled only at the edge where the start is accepted. Later changes on the radicand input have no effect on that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation on the current radicand |
| radicand | input | 32 | Unsigned Q2.30 operand |
| root | output | 32 | Approximate square root, Q2.30 |
| recip | output | 32 | Reciprocal square root, Q16.16, saturated for zero |
| done | output | 1 | One-cycle pulse when root and recip are updated |

## Verification
A corrupted Newton state, such as a wrong seed, a swapped multiplier operand or a bad normalisation shift, has no effect at the ports until the done pulse. At that pulse the root leaves the tolerance band, often by far more than a few LSB. For this reason every done pulse is scored against an independently computed square root and reciprocal. A phase counter that is off by one moves done away from its fixed latency, and this shows up on the first computation. Because the radicand input is scrambled during every computation, a value that is stored at the wrong moment, or a restart that should have been ignored, shows up as a wrong root or as an extra or missing done.

// File: rtl/nr_sqrt.sv
module nr_sqrt #(
  parameter int DW        = 32,
  parameter int ITERS     = 3,
  parameter int GUARD     = 8,
  parameter int SEED_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] radicand,
  output logic [DW-1:0] root,
  output logic [DW-1:0] recip,
  output logic          done
);
  localparam int IW   = DW + GUARD;
  localparam int IF   = IW - 2;
  localparam int KW   = $clog2(DW/2);
  localparam int LAST = 3 * ITERS;
  localparam int PW   = $clog2(LAST + 1);
  localparam int RSH  = IF - DW/2;
  localparam logic [IW-1:0] THREE = IW'(3) << IF;

  function automatic logic [9:0] seed_of(input int idx);
    logic [9:0] r;
    r = '0;
    for (int s = 0; s < 1024; s++)
      if (longint'(s) * s * (2 * idx + 1) <= (longint'(1) << (15 + SEED_BITS)))
        r = 10'(s);
    return r;
  endfunction

  logic [9:0] seed_tab [2**SEED_BITS];
  for (genvar g = 0; g < 2**SEED_BITS; g++) begin : g_seed
    assign seed_tab[g] = seed_of(g);
  end

  logic          active, zero_q;
  logic [KW-1:0] k_q, k_in;
  logic [IW-1:0] m_q, p_q, t_q;
  logic [1:0]    sel;
  logic [PW-1:0] ph;
  logic [DW-1:0] m_in;
  logic [9:0]    seed_in;
  logic [IW-1:0] opa, opb, prodq;

  always_comb begin
    k_in = '0;
    for (int i = 0; i < DW/2; i++)
      if (radicand[2*i +: 2] != 2'b00) k_in = KW'(DW/2 - 1 - i);
  end

  assign m_in    = radicand << (2 * k_in);
  assign seed_in = seed_tab[m_in[DW-1 -: SEED_BITS]];

  always_comb begin
    opa = p_q;
    opb = p_q;
    if (ph == PW'(LAST)) begin
      opa = m_q;
    end else begin
      case (sel)
        2'd0:    opb = p_q;
        2'd1:    begin opa = m_q; opb = t_q; end
        default: opb = THREE - t_q;
      endcase
    end
  end

  assign prodq = IW'(((2*IW)'(opa) * (2*IW)'(opb)) >> IF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      zero_q <= 1'b0;
      k_q    <= '0;
      m_q    <= '0;
      p_q    <= '0;
      t_q    <= '0;
      sel    <= '0;
      ph     <= '0;
      root   <= '0;
      recip  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          zero_q <= (radicand == '0);
          k_q    <= k_in;
          m_q    <= {m_in, {GUARD{1'b0}}};
          p_q    <= IW'(seed_in) << (IF - 8);
          sel    <= '0;
          ph     <= '0;
        end
      end else if (ph == PW'(LAST)) begin
        active <= 1'b0;
        done   <= 1'b1;
        root   <= zero_q ? '0 : DW'(prodq >> (GUARD + int'(k_q)));
        recip  <= zero_q ? '1 : DW'(p_q >> (RSH - int'(k_q)));
      end else begin
        ph  <= ph + 1'b1;
        sel <= (sel == 2'd2) ? 2'd0 : sel + 2'd1;
        if (sel == 2'd2) p_q <= prodq >> 1;
        else             t_q <= prodq;
      end
    end
  end
endmodule

// File: rtl/nr_sqrt_chk.sv
module nr_sqrt_chk #(
  parameter int DW    = 32,
  parameter int ITERS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] root,
  input logic [DW-1:0] recip,
  input logic          done
);
  localparam int LAT = 3 * ITERS + 1;
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= 0;
    else if (cnt == 0) begin if (start) cnt <= LAT; end
    else               cnt <= cnt - 1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 1) |=> done); // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(cnt) == 1)); // R6
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(root) && $stable(recip))); // R7
  AST_ZERO_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (done && root == '0) |-> (recip == '1)); // R5
  AST_ROOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (root <= (DW'(1) << (DW-1)))); // R3
endmodule

bind nr_sqrt nr_sqrt_chk #(.DW(DW), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .root(root), .recip(recip), .done(done)
);

// File: tb/tb_nr_sqrt.sv
`timescale 1ns/1ps
module tb_nr_sqrt;
  localparam int ITERS = 3;
  localparam int LAT   = 3 * ITERS + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] radicand = '0;
  logic [31:0] root, recip;
  logic        done;

  int nchk = 0, nfail = 0;
  bit fin = 0;
  string cur_req = "R3";

  int          mcnt = 0;
  bit          mdone = 0;
  logic [31:0] mx = '0, hroot = '0, hrecip = '0;

  nr_sqrt #(.ITERS(ITERS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .radicand(radicand),
    .root(root), .recip(recip), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned isqrt(input longint unsigned v);
    longint unsigned r;
    r = longint'($floor($sqrt(real'(v))));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  // behavioural reference: acceptance, latency and captured operand
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt  = 0;
      mdone = 0;
    end else begin
      mdone = (mcnt == 1);
      if (mcnt == 0) begin
        if (start) begin mcnt = LAT; mx = radicand; end
      end else mcnt--;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(done === mdone, "R2", "done", 32'(done), 32'(mdone));
      if (mdone) begin
        if (mx == 0) begin
          chk(root == 0, "R5", "root of zero", root, 0);
          chk(recip == 32'hFFFF_FFFF, "R5", "recip of zero", recip, 32'hFFFF_FFFF);
        end else begin
          longint unsigned er;
          longint          d;
          real             rr, ea, tol;
          er = isqrt({longint'(mx), 30'd0});
          d  = longint'(root) - longint'(er);
          chk(d >= -2 && d <= 2, cur_req, "root", root, 32'(er));
          rr  = 2.0 ** 31 / $sqrt(real'(mx));
          ea  = real'(recip) - rr;
          tol = 2.0 + rr / (2.0 ** 24);
          chk(ea <= tol && ea >= -tol, "R4", "recip", recip, 32'(longint'(rr)));
        end
        hroot  = root;
        hrecip = recip;
      end else begin
        chk(root === hroot, "R7", "root held", root, hroot);
        chk(recip === hrecip, "R7", "recip held", recip, hrecip);
      end
    end
  end

  task automatic run(input logic [31:0] x, input string tag);
    @(negedge clk);
    cur_req  = tag;
    start    = 1'b1;
    radicand = x;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 1) begin
      radicand = $urandom; // R8: operand scrambled while busy
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(root == 0 && recip == 0 && done == 0, "R1", "reset outputs", root | recip, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(root == 0, "R1", "root after reset", root, 0);
    chk(recip == 0, "R1", "recip after reset", recip, 0);
    chk(done == 0, "R1", "done after reset", 32'(done), 0);

    run(32'h4000_0000, "R3");   // exactly 1.0
    run(32'hFFFF_FFFF, "R3");   // largest input
    run(32'h0000_0000, "R5");
    run(32'h0000_0001, "R3");   // smallest nonzero
    run(32'h0000_0002, "R3");
    run(32'h8000_0000, "R3");
    run(32'h1000_0000, "R3");
    run(32'h0000_0000, "R5");
    for (int i = 0; i < 120; i++) run($urandom, "R3");
    for (int i = 0; i < 80; i++) run($urandom >> ($urandom % 32), "R8");

    // R6: repeated start requests during a computation
    @(negedge clk);
    cur_req = "R6";
    start = 1'b1;
    radicand = 32'h2400_0000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      radicand = $urandom;
    end
    start = 1'b0;
    repeat (LAT + 2) @(negedge clk);

    // R6: start held high, the request at the done edge is ignored
    start = 1'b1;
    for (int i = 0; i < 45; i++) begin
      radicand = $urandom;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (LAT + 3) @(negedge clk);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule